// File: doc/BRIEF.md
# Hamming-Coded Parallel FIR Bank

This block runs four copies of one fixed-tap FIR filter, one per sample lane. It repairs any single lane whose filter output has gone wrong by treating each whole filter as one data bit of a (7,4) Hamming code. A small adder stage forms three checksum streams from the four lane inputs. Each checksum is the sum of three lanes. Three more copies of the same filter process these checksum streams. Because the filters are linear, each redundant output must equal the sum of the matching functional outputs.

A correction stage compares every redundant output with the sum of its member lanes and forms a three-bit syndrome. If the syndrome names exactly one lane, that lane is rebuilt from a check equation and the remaining lanes. A zero syndrome passes the lanes through untouched. Any other pattern passes them through and raises an uncorrectable flag. Per-lane override ports replace a functional filter's output before the check, so that faults can be injected from outside.

Top module: `hfb_bank`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, all filter state clears. `y_out`, `syndrome`, `fix_lane` and `uncorrectable` read zero, whatever the lane inputs are.
- R2: Each lane computes y[n] = sum over k of c[k]·x[n−k], using unsigned samples and unsigned taps. With the defaults the taps are c = 4, 3, 8, 9 and each lane is 9 bits. A sample driven before clock edge n appears on `y_out` after edge n+1, so the lane path has two register stages.
- R3: The three check streams carry lane sums: check 1 is lanes 1+2+3, check 2 is lanes 1+2+4, check 3 is lanes 1+3+4. Each redundant filter output equals the sum of its member lanes' fault-free outputs, with no overflow even at full-scale input.
- R4: `syndrome[2]` is set when check 1 disagrees with its members' outputs. `syndrome[1]` does the same for check 2 and `syndrome[0]` for check 3.
- R5: A zero syndrome passes all four lane outputs unchanged and leaves `fix_lane` and `uncorrectable` low.
- R6: Syndrome 111 marks lane 1, 110 lane 2, 101 lane 3 and 011 lane 4. The marked lane's output is replaced and `fix_lane` bit i−1 (one-hot) is set for lane i.
- R7: A marked lane is rebuilt from the lowest-numbered check that contains it: the redundant output minus its other two members' outputs. Lane 4 therefore uses check 2. This holds even when multiple faults alias onto a single-lane syndrome.
- R8: Syndromes 100, 010 and 001 pass the lanes through unmodified, set `uncorrectable` and leave `fix_lane` at zero.
- R9: When `inj_en[i]` is high, `inj_val[i]` replaces lane i+1's filter output ahead of the checks. Outputs and status follow a change on these ports one clock edge later. An override equal to the fault-free value has no effect.
- R10: `fix_lane` is never more than one-hot, and it is never nonzero in the same cycle as `uncorrectable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 4×DATA_W | Lane samples, element 0 is lane 1 |
| inj_en | input | 4 | Per-lane output override enable |
| inj_val | input | 4×Y_W | Per-lane override value |
| y_out | output | 4×Y_W | Corrected lane outputs, element 0 is lane 1 |
| syndrome | output | 3 | Registered syndrome, bit 2 is check 1 |
| fix_lane | output | 4 | One-hot lane that was rebuilt |
| uncorrectable | output | 1 | Syndrome matched no single lane |

## Verification
The bench builds the block with its default parameters: 4-bit samples and four taps 4, 3, 8, 9. This gives 9-bit lanes and 11-bit checksums. At these widths a full-scale input of 15 drives each lane to 360 and each checksum to 1080, which exercises the guard bits. Overrides can also reach the lane ceiling of 511. Small constant inputs (2, 3, 4, 5) give lane values of 48, 72, 96 and 120. Against those values, coordinated multi-lane overrides produce every syndrome pattern, including the single-bit ones and an aliased miscorrection.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
  localparam int LANES    = 4;
  localparam int CHECKS   = 3;
  localparam int MAX_TAPS = 8;
  localparam int COEF_W   = 8;

  typedef logic [MAX_TAPS-1:0][COEF_W-1:0] coef_vec_t;

  // element k is the weight of x[n-k]
  localparam coef_vec_t DEFAULT_COEFS =
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd9, 8'd8, 8'd3, 8'd4};

  // check j covers the lanes whose bit is set (bit 0 = lane 1)
  localparam logic [CHECKS-1:0][LANES-1:0] CHECK_MASK =
    {4'b1101, 4'b1011, 4'b0111};

  // full-precision width of one filter for unsigned data
  function automatic int fir_width(int dw, int taps, coef_vec_t c);
    int tap_sum;
    tap_sum = 0;
    for (int k = 0; k < taps; k++) tap_sum += int'(c[k]);
    return $clog2(((1 << dw) - 1) * tap_sum + 1);
  endfunction

  // syndrome signature of a lane, check 1 in the MSB
  function automatic logic [CHECKS-1:0] lane_code(int lane);
    logic [CHECKS-1:0] code;
    for (int j = 0; j < CHECKS; j++) code[CHECKS-1-j] = CHECK_MASK[j][lane];
    return code;
  endfunction

  // lowest-numbered check that contains the lane
  function automatic int first_check(int lane);
    for (int j = 0; j < CHECKS; j++)
      if (CHECK_MASK[j][lane]) return j;
    return 0;
  endfunction
endpackage

// File: rtl/hfb_fir.sv
module hfb_fir #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 9,
  parameter int TAPS  = 4,
  parameter hfb_pkg::coef_vec_t COEFS = hfb_pkg::DEFAULT_COEFS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  x,
  output logic [OUT_W-1:0] y
);
  localparam int HIST = TAPS - 1;

  logic [HIST-1:0][IN_W-1:0] hist_q;
  logic [OUT_W-1:0]          acc;

  always_comb begin
    acc = OUT_W'(COEFS[0]) * OUT_W'(x);
    for (int k = 1; k < TAPS; k++)
      acc = acc + OUT_W'(COEFS[k]) * OUT_W'(hist_q[k-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      y      <= '0;
    end else begin
      hist_q[0] <= x;
      for (int k = 1; k < HIST; k++) hist_q[k] <= hist_q[k-1];
      y <= acc;
    end
  end
endmodule

// File: rtl/hfb_encoder.sv
module hfb_encoder #(
  parameter int IN_W  = 4,
  parameter int SUM_W = 6
) (
  input  logic [hfb_pkg::LANES-1:0][IN_W-1:0]   x,
  output logic [hfb_pkg::CHECKS-1:0][SUM_W-1:0] xs
);
  always_comb begin
    for (int j = 0; j < hfb_pkg::CHECKS; j++) begin
      xs[j] = '0;
      for (int i = 0; i < hfb_pkg::LANES; i++)
        if (hfb_pkg::CHECK_MASK[j][i]) xs[j] = xs[j] + SUM_W'(x[i]);
    end
  end
endmodule

// File: rtl/hfb_corrector.sv
module hfb_corrector #(
  parameter int Y_W = 9,
  parameter int Z_W = 11
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [hfb_pkg::LANES-1:0][Y_W-1:0]  y,
  input  logic [hfb_pkg::CHECKS-1:0][Z_W-1:0] z,
  output logic [hfb_pkg::CHECKS-1:0]          syn_now,
  output logic [hfb_pkg::LANES-1:0][Y_W-1:0]  y_fix,
  output logic [hfb_pkg::CHECKS-1:0]          syn_q,
  output logic [hfb_pkg::LANES-1:0]           fix_q,
  output logic                                bad_q
);
  localparam int L = hfb_pkg::LANES;
  localparam int C = hfb_pkg::CHECKS;

  // sum of the members of check j, leaving out lane skip (-1 keeps all)
  function automatic logic [Z_W-1:0] member_sum(int j, logic [L-1:0][Y_W-1:0] v, int skip);
    logic [Z_W-1:0] s;
    s = '0;
    for (int i = 0; i < L; i++)
      if (hfb_pkg::CHECK_MASK[j][i] && i != skip) s = s + Z_W'(v[i]);
    return s;
  endfunction

  logic [L-1:0]          lane_hit;
  logic [L-1:0][Y_W-1:0] rebuilt;
  logic [L-1:0][Y_W-1:0] fix_next;
  logic                  bad_now;

  always_comb begin
    for (int j = 0; j < C; j++)
      syn_now[C-1-j] = (z[j] != member_sum(j, y, -1));
    for (int i = 0; i < L; i++) begin
      lane_hit[i] = (syn_now == hfb_pkg::lane_code(i));
      rebuilt[i]  = Y_W'(z[hfb_pkg::first_check(i)]
                         - member_sum(hfb_pkg::first_check(i), y, i));
      fix_next[i] = lane_hit[i] ? rebuilt[i] : y[i];
    end
    bad_now = (syn_now != '0) && (lane_hit == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_fix <= '0;
      syn_q <= '0;
      fix_q <= '0;
      bad_q <= 1'b0;
    end else begin
      y_fix <= fix_next;
      syn_q <= syn_now;
      fix_q <= lane_hit;
      bad_q <= bad_now;
    end
  end
endmodule

// File: rtl/hfb_bank.sv
module hfb_bank #(
  parameter int DATA_W = 4,
  parameter int TAPS   = 4,
  parameter hfb_pkg::coef_vec_t COEFS = hfb_pkg::DEFAULT_COEFS,
  localparam int Y_W   = hfb_pkg::fir_width(DATA_W, TAPS, COEFS),
  localparam int Z_W   = Y_W + 2,
  localparam int SUM_W = DATA_W + 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [hfb_pkg::LANES-1:0][DATA_W-1:0] x_in,
  input  logic [hfb_pkg::LANES-1:0]             inj_en,
  input  logic [hfb_pkg::LANES-1:0][Y_W-1:0]    inj_val,
  output logic [hfb_pkg::LANES-1:0][Y_W-1:0]    y_out,
  output logic [hfb_pkg::CHECKS-1:0]            syndrome,
  output logic [hfb_pkg::LANES-1:0]             fix_lane,
  output logic                                  uncorrectable
);
  localparam int L = hfb_pkg::LANES;
  localparam int C = hfb_pkg::CHECKS;

  logic [L-1:0][Y_W-1:0]   y_clean;
  logic [L-1:0][Y_W-1:0]   y_used;
  logic [C-1:0][SUM_W-1:0] xs;
  logic [C-1:0][Z_W-1:0]   z;
  logic [C-1:0]            syn_now;

  for (genvar i = 0; i < L; i++) begin : g_func
    hfb_fir #(.IN_W(DATA_W), .OUT_W(Y_W), .TAPS(TAPS), .COEFS(COEFS)) u_fir (
      .clk(clk), .rst_n(rst_n), .x(x_in[i]), .y(y_clean[i]));
  end

  hfb_encoder #(.IN_W(DATA_W), .SUM_W(SUM_W)) u_enc (.x(x_in), .xs(xs));

  for (genvar j = 0; j < C; j++) begin : g_red
    hfb_fir #(.IN_W(SUM_W), .OUT_W(Z_W), .TAPS(TAPS), .COEFS(COEFS)) u_fir (
      .clk(clk), .rst_n(rst_n), .x(xs[j]), .y(z[j]));
  end

  always_comb begin
    for (int i = 0; i < L; i++)
      y_used[i] = inj_en[i] ? inj_val[i] : y_clean[i];
  end

  hfb_corrector #(.Y_W(Y_W), .Z_W(Z_W)) u_cor (
    .clk(clk), .rst_n(rst_n), .y(y_used), .z(z), .syn_now(syn_now),
    .y_fix(y_out), .syn_q(syndrome), .fix_q(fix_lane), .bad_q(uncorrectable));
endmodule

// File: rtl/hfb_bank_chk.sv
module hfb_bank_chk #(
  parameter int Y_W = 9,
  parameter int Z_W = 11
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [hfb_pkg::LANES-1:0]           inj_en,
  input logic [hfb_pkg::LANES-1:0][Y_W-1:0]  y_clean,
  input logic [hfb_pkg::LANES-1:0][Y_W-1:0]  y_used,
  input logic [hfb_pkg::CHECKS-1:0][Z_W-1:0] z,
  input logic [hfb_pkg::CHECKS-1:0]          syn_now,
  input logic [hfb_pkg::LANES-1:0][Y_W-1:0]  y_out,
  input logic [hfb_pkg::CHECKS-1:0]          syndrome,
  input logic [hfb_pkg::LANES-1:0]           fix_lane,
  input logic                                uncorrectable
);
  // R3
  check1_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z[0] == Z_W'(y_clean[0]) + Z_W'(y_clean[1]) + Z_W'(y_clean[2]));
  // R3
  check2_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z[1] == Z_W'(y_clean[0]) + Z_W'(y_clean[1]) + Z_W'(y_clean[3]));
  // R3
  check3_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z[2] == Z_W'(y_clean[0]) + Z_W'(y_clean[2]) + Z_W'(y_clean[3]));
  // R5
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_now == '0) |=> (y_out == $past(y_used)) && fix_lane == '0 && !uncorrectable);
  // R6
  single_fault_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(inj_en) == 1) |=> (y_out == $past(y_clean)));
  // R8
  parity_only_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(syn_now) == 1) |=> uncorrectable && fix_lane == '0 && $countones(syndrome) == 1);
  // R10
  fix_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fix_lane) && !(uncorrectable && fix_lane != '0));
endmodule

bind hfb_bank hfb_bank_chk #(.Y_W(Y_W), .Z_W(Z_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .y_clean(y_clean), .y_used(y_used),
  .z(z), .syn_now(syn_now), .y_out(y_out), .syndrome(syndrome),
  .fix_lane(fix_lane), .uncorrectable(uncorrectable));

// File: tb/hfb_bank_test.sv
module hfb_bank_test;
  localparam int YW = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [3:0][3:0]  x_in;
  logic [3:0]       inj_en;
  logic [3:0][YW-1:0] inj_val;
  logic [3:0][YW-1:0] y_out;
  logic [2:0]       syndrome;
  logic [3:0]       fix_lane;
  logic             uncorrectable;

  hfb_bank uut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .inj_en(inj_en), .inj_val(inj_val),
    .y_out(y_out), .syndrome(syndrome), .fix_lane(fix_lane),
    .uncorrectable(uncorrectable));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam int TAP [4] = '{4, 3, 8, 9};
  localparam logic [3:0][8:0] BASE = {9'd120, 9'd96, 9'd72, 9'd48};

  typedef struct packed {
    logic [3:0]      en;
    logic [3:0][8:0] val;
    logic [2:0]      syn;
    logic [3:0]      fix;
    logic            unc;
    logic [3:0][8:0] exp;
  } vec_t;

  // lanes written lane 4 first; steady lane values 48, 72, 96, 120
  localparam vec_t VECS [12] = '{
    '{4'b0000, {9'd0,   9'd0,  9'd0,  9'd0 }, 3'b000, 4'b0000, 1'b0, BASE},
    '{4'b0001, {9'd0,   9'd0,  9'd0,  9'd49}, 3'b111, 4'b0001, 1'b0, BASE},
    '{4'b0010, {9'd0,   9'd0,  9'd76, 9'd0 }, 3'b110, 4'b0010, 1'b0, BASE},
    '{4'b0100, {9'd0,   9'd97, 9'd0,  9'd0 }, 3'b101, 4'b0100, 1'b0, BASE},
    '{4'b1000, {9'd121, 9'd0,  9'd0,  9'd0 }, 3'b011, 4'b1000, 1'b0, BASE},
    '{4'b0001, {9'd0,   9'd0,  9'd0,  9'd0 }, 3'b111, 4'b0001, 1'b0, BASE},
    '{4'b1000, {9'd511, 9'd0,  9'd0,  9'd0 }, 3'b011, 4'b1000, 1'b0, BASE},
    '{4'b0111, {9'd0,   9'd97, 9'd73, 9'd47}, 3'b100, 4'b0000, 1'b1, {9'd120, 9'd97, 9'd73, 9'd47}},
    '{4'b1011, {9'd121, 9'd0,  9'd73, 9'd47}, 3'b010, 4'b0000, 1'b1, {9'd121, 9'd96, 9'd73, 9'd47}},
    '{4'b1101, {9'd121, 9'd97, 9'd0,  9'd47}, 3'b001, 4'b0000, 1'b1, {9'd121, 9'd97, 9'd72, 9'd47}},
    '{4'b0110, {9'd0,   9'd95, 9'd73, 9'd0 }, 3'b011, 4'b1000, 1'b0, {9'd119, 9'd95, 9'd73, 9'd48}},
    '{4'b0010, {9'd0,   9'd0,  9'd72, 9'd0 }, 3'b000, 4'b0000, 1'b0, BASE}
  };

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n   = 1'b0;
    x_in    = {4'd5, 4'd4, 4'd3, 4'd2};
    inj_en  = '0;
    inj_val = '0;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero even with inputs applied
    for (int i = 0; i < 4; i++) chk("R1", "reset lane", y_out[i], 0);
    chk("R1", "reset syndrome", syndrome, 0);
    chk("R1", "reset fix_lane", fix_lane, 0);
    chk("R1", "reset flag", uncorrectable, 0);

    x_in  = '0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: impulse response, lane 1 weight 1, lane 2 weight 15
    x_in = {4'd0, 4'd0, 4'd15, 4'd1};
    @(negedge clk);
    x_in = '0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R2", "impulse lane1", y_out[0], (k < 4) ? TAP[k] : 0);
      chk("R2", "impulse lane2", y_out[1], (k < 4) ? 15 * TAP[k] : 0);
      chk("R5", "impulse syndrome", syndrome, 0);
    end

    // steady lanes 48, 72, 96, 120
    x_in = {4'd5, 4'd4, 4'd3, 4'd2};
    repeat (6) @(negedge clk);

    // R9: an override takes effect at the next edge, not before
    inj_en  = 4'b0001;
    inj_val = {9'd0, 9'd0, 9'd0, 9'd49};
    #9;
    chk("R9", "pre-edge syndrome", syndrome, 0);
    chk("R9", "pre-edge fix_lane", fix_lane, 0);
    @(negedge clk);
    chk("R9", "post-edge syndrome", syndrome, 3'b111);
    inj_en = '0;
    @(negedge clk);

    // R4 R5 R6 R7 R8: vector walk
    for (int v = 0; v < 12; v++) begin
      inj_en  = VECS[v].en;
      inj_val = VECS[v].val;
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        chk((v == 10) ? "R7" : ((v >= 7 && v <= 9) ? "R8" : "R6"),
            $sformatf("vector %0d lane%0d", v, i + 1), y_out[i], VECS[v].exp[i]);
      chk("R4", $sformatf("vector %0d syndrome", v), syndrome, VECS[v].syn);
      chk("R6", $sformatf("vector %0d fix_lane", v), fix_lane, VECS[v].fix);
      chk("R8", $sformatf("vector %0d flag", v), uncorrectable, VECS[v].unc);
    end
    inj_en = '0;

    // R3: full-scale inputs fit in the checksum path
    x_in = {4'd15, 4'd15, 4'd15, 4'd15};
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R3", "full-scale lane", y_out[i], 360);
    chk("R3", "full-scale syndrome", syndrome, 0);
    chk("R3", "full-scale flag", uncorrectable, 0);

    // R1: asynchronous reset mid-run with an override active
    inj_en  = 4'b0100;
    inj_val = {9'd0, 9'd3, 9'd0, 9'd0};
    @(negedge clk);
    chk("R6", "full-scale fix", y_out[2], 360);
    #3 rst_n = 1'b0;
    #2;
    chk("R1", "async reset lane3", y_out[2], 0);
    chk("R1", "async reset fix_lane", fix_lane, 0);
    chk("R1", "async reset syndrome", syndrome, 0);

    done = 1'b1;
    finish_run();
  end
endmodule